// File: doc/BRIEF.md
# Receive FIFO with Programmable Fill Thresholds

This block buffers incoming data words in a first-in, first-out store. It reports how full that store is through a small register set. A producer presents words on a parallel input port, and each word is taken only while reception is enabled. A consumer removes words in one of two ways: it reads a fixed data register, or it follows a demand handshake meant for a DMA engine.

Software programs two fill levels, one for almost-empty and one for almost-full, and packs both into a single register. Status is reported as active-high "not" flags: not-empty, not-almost-empty, not-almost-full and not-full. Two sticky error bits record a word that arrived while the store was full and a read attempted while it was empty. Each error bit is cleared by writing 1 to it.

A whole-block reset, issued by software or by the reset pin, starts a hold-off window. While the window is open, the store cannot be pushed, popped or read. A store flush clears only the queued data.

Top module: `rxq_thresh_fifo`

## Requirements
- R1: After the reset pin or a block reset (a control write with bit 0 set), the control register reads 0 (receive disabled), the threshold register reads 0x00200020 (both levels 32), both sticky bits read 0 and the store is empty.
- R2: For HOLD_CYCLES clock edges after a reset, the store is frozen. Input words are dropped, a data register read returns 0 and pops nothing, and dma_req stays low. Registers other than the data register stay accessible.
- R3: A word on in_data with in_valid high is stored only while control bit 5 (receive enable) is 1. Words leave in arrival order.
- R4: The count register reads the number of stored words, updated at the clock edge of each accepted push or pop. It never exceeds DEPTH.
- R5: Status bit 12 is 1 when count is not 0, and status bit 15 is 1 when count is not DEPTH.
- R6: Threshold bits 15:0 hold the almost-empty level AE. Status bit 13 is 1 exactly when count > AE.
- R7: Threshold bits 23:16 hold the almost-full level AF. Status bit 14 is 1 exactly when (DEPTH - count) > AF.
- R8: A word offered while the store is full is dropped, and it sets status bit 23 (overrun). The bit stays set until it is cleared.
- R9: A pop attempt on an empty store, through the data register or through dma_ack, sets status bit 22 (underrun). The bit stays set until it is cleared.
- R10: A status write clears bit 23 and/or bit 22 where the written value has a 1. All other status bits ignore writes.
- R11: A control write with bit 2 set empties the store. The sticky bits are kept, and the enable takes the written bit 5.
- R12: dma_req is high exactly when the store is not empty and not frozen. dma_data shows the oldest word, and dma_ack pops it.
- R13: The word addresses are control 0, status 1, threshold 2, size 3, count 4 and data 5. The size register reads DEPTH in bits 19:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the data register pops) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input word |
| dma_req | output | 1 | Demand request: a word is available |
| dma_ack | input | 1 | Demand acknowledge: pop the oldest word |
| dma_data | output | DATA_W | Oldest stored word |

## Verification
The threshold flags are swept over a small store of 16 words. For each of four (AE, AF) pairs, the store is filled one word at a time and then drained one word at a time, and the full status word is compared after every step. The pairs run from (0,15) to (15,0), which separates the strict comparisons from the off-by-one variants at both ends of the store. A word pushed past full and a read past empty tell the two sticky bits apart, and partial write-1-to-clear patterns show that each bit is cleared separately. The hold-off window is probed on its last frozen edge and just after it, and both the flush path and the DMA drain path are exercised against the same arrival order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic [2:0] {
      A_CTRL = 3'd0,
      A_STAT = 3'd1,
      A_THR  = 3'd2,
      A_SIZE = 3'd3,
      A_CNT  = 3'd4,
      A_DATA = 3'd5
   } rxq_addr_e;

   // control bit positions
   localparam int CB_BRST = 0;
   localparam int CB_FRST = 2;
   localparam int CB_EN   = 5;
   // status bit positions
   localparam int SB_NE   = 12;
   localparam int SB_NAE  = 13;
   localparam int SB_NAF  = 14;
   localparam int SB_NF   = 15;
   localparam int SB_UDR  = 22;
   localparam int SB_OVR  = 23;
   // threshold reset level
   localparam logic [15:0] THR_DEFAULT = 16'd32;
endpackage

// File: rtl/rxq_holdoff.sv
module rxq_holdoff #(
   parameter int HOLD_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic hold
);
   localparam int HW = $clog2(HOLD_CYCLES + 1);

   logic [HW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= HW'(HOLD_CYCLES);
      else if (start)
         cnt_q <= HW'(HOLD_CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - HW'(1);
   end

   assign hold = (cnt_q != '0);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push_try,
   input  logic                         pop_try,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int  AW   = $clog2(DEPTH);
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     cnt_q;
   logic              push_ok, pop_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push_try && !full;
   assign pop_ok  = pop_try && !empty;

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok && !flush)
         mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign count = cnt_q;
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
   import rxq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   input  logic        set_ovr,
   input  logic        set_udr,
   output logic        en,
   output logic [15:0] ae_lvl,
   output logic [7:0]  af_lvl,
   output logic        ovr,
   output logic        udr,
   output logic        brst,
   output logic        frst
);
   logic wr_ctrl, wr_stat, wr_thr;
   logic unused_hi;

   assign wr_ctrl   = wr && (addr == A_CTRL);
   assign wr_stat   = wr && (addr == A_STAT);
   assign wr_thr    = wr && (addr == A_THR);
   assign brst      = wr_ctrl && wdata[CB_BRST];
   assign frst      = wr_ctrl && wdata[CB_FRST];
   assign unused_hi = ^wdata[31:24];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         ae_lvl <= THR_DEFAULT;
         af_lvl <= THR_DEFAULT[7:0];
         ovr    <= 1'b0;
         udr    <= 1'b0;
      end else if (brst) begin
         en     <= 1'b0;
         ae_lvl <= THR_DEFAULT;
         af_lvl <= THR_DEFAULT[7:0];
         ovr    <= 1'b0;
         udr    <= 1'b0;
      end else begin
         if (wr_ctrl) en <= wdata[CB_EN];
         if (wr_thr) begin
            ae_lvl <= wdata[15:0];
            af_lvl <= wdata[23:16];
         end
         ovr <= set_ovr || (ovr && !(wr_stat && wdata[SB_OVR]));
         udr <= set_udr || (udr && !(wr_stat && wdata[SB_UDR]));
      end
   end
endmodule

// File: rtl/rxq_thresh_fifo.sv
module rxq_thresh_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 64,
   parameter int HOLD_CYCLES = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              dma_req,
   input  logic              dma_ack,
   output logic [DATA_W-1:0] dma_data
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DATA_W >= 1 && DATA_W <= 32) else $error("DATA_W must be 1..32");
      assert (DEPTH >= 2 && DEPTH < (1 << 20)) else $error("DEPTH out of range");
      assert (HOLD_CYCLES >= 1) else $error("HOLD_CYCLES must be at least 1");
   end

   logic              hold_w, en_w, ovr_w, udr_w, brst_w, frst_w;
   logic              full_w, empty_w, push_try, pop_try, data_rd;
   logic [15:0]       ae_w;
   logic [7:0]        af_w;
   logic [CW-1:0]     count_w;
   logic [DATA_W-1:0] head_w;
   logic [31:0]       stat_w, cnt32, free32;

   rxq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(brst_w), .hold(hold_w)
   );

   assign data_rd  = reg_rd && (reg_addr == A_DATA) && !hold_w;
   assign pop_try  = data_rd || (dma_ack && !hold_w);
   assign push_try = in_valid && en_w && !hold_w;

   rxq_csr u_csr (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .set_ovr(push_try && full_w), .set_udr(pop_try && empty_w),
      .en(en_w), .ae_lvl(ae_w), .af_lvl(af_w), .ovr(ovr_w), .udr(udr_w),
      .brst(brst_w), .frst(frst_w)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(brst_w || frst_w),
      .push_try(push_try), .pop_try(pop_try), .wdata(in_data),
      .head(head_w), .count(count_w), .full(full_w), .empty(empty_w)
   );

   assign cnt32  = 32'(count_w);
   assign free32 = 32'(DEPTH) - cnt32;

   always_comb begin
      stat_w         = '0;
      stat_w[SB_NE]  = !empty_w;
      stat_w[SB_NAE] = cnt32 > 32'(ae_w);
      stat_w[SB_NAF] = free32 > 32'(af_w);
      stat_w[SB_NF]  = !full_w;
      stat_w[SB_UDR] = udr_w;
      stat_w[SB_OVR] = ovr_w;
   end

   always_comb begin
      case (rxq_addr_e'(reg_addr))
         A_CTRL:  reg_rdata = 32'(en_w) << CB_EN;
         A_STAT:  reg_rdata = stat_w;
         A_THR:   reg_rdata = {8'd0, af_w, ae_w};
         A_SIZE:  reg_rdata = {12'd0, 20'(DEPTH)};
         A_CNT:   reg_rdata = cnt32;
         A_DATA:  reg_rdata = hold_w ? 32'd0 : 32'(head_w);
         default: reg_rdata = 32'd0;
      endcase
   end

   assign dma_req  = !empty_w && !hold_w;
   assign dma_data = head_w;
endmodule

// File: rtl/rxq_thresh_fifo_chk.sv
module rxq_thresh_fifo_chk #(
   parameter int DEPTH = 64,
   parameter int CW    = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] count,
   input logic          hold,
   input logic          dma_req,
   input logic          ovr,
   input logic          udr,
   input logic          push_try,
   input logic          pop_try,
   input logic          brst,
   input logic          frst
);
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(count) <= 32'(DEPTH));

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!brst && !frst) |=> (count == $past(count)) || (32'(count) == 32'($past(count)) + 1)
                           || (32'(count) + 1 == 32'($past(count))));

   // R12
   dma_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (count != '0) && !hold);

   // R2
   hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> count == '0);

   // R8
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_try && 32'(count) == 32'(DEPTH) && !brst) |=> ovr);

   // R9
   udr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_try && count == '0 && !brst) |=> udr);
endmodule

bind rxq_thresh_fifo rxq_thresh_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .count(count_w), .hold(hold_w), .dma_req(dma_req),
   .ovr(ovr_w), .udr(udr_w), .push_try(push_try), .pop_try(pop_try),
   .brst(brst_w), .frst(frst_w)
);

// File: tb/rxq_thresh_fifo_tb.sv
module rxq_thresh_fifo_tb;
   localparam int DW    = 32;
   localparam int DEPTH = 16;
   localparam int HOLD  = 50;
   localparam logic [2:0] AC = 3'd0, AS = 3'd1, AT = 3'd2, AZ = 3'd3, AN = 3'd4, AD = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          dma_req;
   logic          dma_ack = 1'b0;
   logic [DW-1:0] dma_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] rv;

   always #5 clk = ~clk;

   rxq_thresh_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .HOLD_CYCLES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_data(in_data),
      .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic push(input logic [31:0] d);
      @(negedge clk); in_valid = 1'b1; in_data = d;
      @(negedge clk); in_valid = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); dma_ack = 1'b1;
      @(negedge clk); dma_ack = 1'b0;
   endtask

   function automatic logic [31:0] exp_stat(int k, int ae, int af, bit ov, bit ud);
      logic [31:0] s = '0;
      s[12] = (k != 0);
      s[13] = (k > ae);
      s[14] = ((DEPTH - k) > af);
      s[15] = (k != DEPTH);
      s[22] = ud;
      s[23] = ov;
      return s;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // hold-off after the reset pin
      wr_reg(AC, 32'h20);
      push(32'h1111_1111);
      rd_reg(AN, rv); chk("R2 push during hold dropped", rv, 32'd0);
      rd_reg(AD, rv); chk("R2 data read during hold", rv, 32'd0);
      chk("R2 dma_req low during hold", 32'(dma_req), 32'd0);
      repeat (HOLD + 5) @(negedge clk);
      rd_reg(AN, rv); chk("R2 count after hold", rv, 32'd0);
      rd_reg(AS, rv); chk("R1 status at reset", rv, 32'h0000_8000);
      rd_reg(AT, rv); chk("R1 threshold defaults", rv, 32'h0020_0020);
      rd_reg(AZ, rv); chk("R13 size register", rv, 32'(DEPTH));
      rd_reg(AC, rv); chk("R3 enable readback", rv, 32'h20);

      // receive disabled
      wr_reg(AC, 32'h0);
      push(32'h2222_2222);
      rd_reg(AN, rv); chk("R3 push ignored when disabled", rv, 32'd0);
      wr_reg(AC, 32'h20);

      // threshold sweep: fill and drain
      for (int p = 0; p < 4; p++) begin
         int ae = p * 5;
         int af = 15 - p * 5;
         logic [31:0] base = 32'hC0DE_0000 + (p << 8);
         wr_reg(AT, (af << 16) | ae);
         rd_reg(AT, rv); chk("R6 R7 threshold readback", rv, 32'((af << 16) | ae));
         for (int k = 1; k <= DEPTH; k++) begin
            push(base + k);
            rd_reg(AN, rv); chk("R4 count on fill", rv, 32'(k));
            rd_reg(AS, rv); chk("R5 R6 R7 status on fill", rv, exp_stat(k, ae, af, 0, 0));
         end
         push(base + 32'hFF);
         rd_reg(AN, rv); chk("R8 count after overrun", rv, 32'(DEPTH));
         rd_reg(AS, rv); chk("R8 overrun sticky", rv, exp_stat(DEPTH, ae, af, 1, 0));
         for (int k = 1; k <= DEPTH; k++) begin
            rd_reg(AD, rv); chk("R3 data order", rv, base + k);
            rd_reg(AS, rv); chk("R5 R6 R7 status on drain", rv, exp_stat(DEPTH - k, ae, af, 1, 0));
         end
         rd_reg(AD, rv);
         rd_reg(AS, rv); chk("R9 underrun on empty read", rv, exp_stat(0, ae, af, 1, 1));
         wr_reg(AS, 32'h0080_F000);
         rd_reg(AS, rv); chk("R10 clear overrun only", rv, exp_stat(0, ae, af, 0, 1));
         wr_reg(AS, 32'h0040_0000);
         rd_reg(AS, rv); chk("R10 clear underrun", rv, exp_stat(0, ae, af, 0, 0));
      end

      // store flush keeps sticky bits (thresholds ae=15 af=0)
      rd_reg(AD, rv);
      push(32'hAAAA_0001); push(32'hAAAA_0002); push(32'hAAAA_0003);
      wr_reg(AC, 32'h24);
      rd_reg(AN, rv); chk("R11 flush empties", rv, 32'd0);
      rd_reg(AC, rv); chk("R11 enable after flush", rv, 32'h20);
      rd_reg(AS, rv); chk("R11 sticky kept", rv, exp_stat(0, 15, 0, 0, 1));
      push(32'hBBBB_0001);
      rd_reg(AD, rv); chk("R11 data after flush", rv, 32'hBBBB_0001);
      wr_reg(AS, 32'h0040_0000);

      // DMA drain
      push(32'hD000_0000); push(32'hD000_0001); push(32'hD000_0002);
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R12 dma_req while data", 32'(dma_req), 32'd1);
         chk("R12 dma_data order", dma_data, 32'hD000_0000 + k);
         ack();
      end
      #1 chk("R12 dma_req low when empty", 32'(dma_req), 32'd0);
      ack();
      rd_reg(AS, rv); chk("R9 underrun via dma_ack", rv, exp_stat(0, 15, 0, 0, 1));

      // block reset and hold-off boundary
      wr_reg(AT, 32'h0005_0005);
      wr_reg(AC, 32'h21);
      wr_reg(AC, 32'h20);
      #1 chk("R2 dma_req low in hold", 32'(dma_req), 32'd0);
      repeat (HOLD - 4) @(negedge clk);
      push(32'hE000_0001);
      push(32'hE000_0002);
      rd_reg(AN, rv); chk("R2 last hold edge drops, next accepts", rv, 32'd1);
      rd_reg(AD, rv); chk("R2 accepted word after hold", rv, 32'hE000_0002);
      rd_reg(AT, rv); chk("R1 thresholds after block reset", rv, 32'h0020_0020);
      rd_reg(AS, rv); chk("R1 status after block reset", rv, 32'h0000_8000);
      wr_reg(AC, 32'h01);
      rd_reg(AC, rv); chk("R1 control after block reset", rv, 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule